// File: doc/BRIEF.md
# Block-based security lookup table

This block keeps one security bit for every fixed-size block of a protected memory. A bit at 1 marks its block non-secure, and a bit at 0 marks it secure. The bits are packed 32 to a word. Software never addresses a table word directly. It first loads a word index register. It then reads or writes the word that the index selects through a single data window register. The whole table is also presented as a flat vector on `sec_map_o`, and a separate access-checking block consumes that vector.

Filling a large table takes many accesses, so the index can step forward by itself after each full-word access to the data window. A sticky lock bit in the control register freezes the security configuration until the next reset. Several registers are fixed and read-only:
- the highest legal word index;
- the block-size code;
- a set of identification words, one of which carries a version code.

All access goes through a simple 32-bit register bus. A read returns its data in the cycle after the request.

Top module: `sec_blk_lut`

## Requirements
- R1: After reset, the control register reads 0, the index register reads 0, and every table bit is 0 (all blocks secure).
- R2: Offset 0x10 reads NUM_WORDS-1, the highest legal word index. Offset 0x14 reads BLK_CFG, and a block spans 2^(BLK_CFG+5) bytes. Offsets 0x04, 0x08 and 0x0C read 0.
- R3: A write to the data window (0x1C) stores into the word selected by the index (0x18), and a read there returns that word. Bit n of word w drives `sec_map_o[32*w+n]`, where 1 means non-secure.
- R4: A write with only some byte strobes set changes only the enabled bytes of the selected word, and it never advances the index.
- R5: When control bit 8 (auto-step) is 1, each read and each full-word write of the data window advances the index by one. When the bit is 0, the index does not move.
- R6: A write to the index register of a value above NUM_WORDS-1 is dropped, and the index keeps its old value.
- R7: Auto-step stops at NUM_WORDS, one past the last word. At that index, data window reads return 0, writes leave the table unchanged, and the index stays put.
- R8: Control bit 31 (lock) is set by writing 1 to it, and only reset clears it.
- R9: While lock is 1, writes to the control, index and data window registers are ignored, and a dropped data write does not advance the index. Reads still return current values, and data window reads still auto-step.
- R10: The identification words sit at 0xFD0 to 0xFFC in 4-byte steps, with these values:

  | Offset | Value |
  |---|---|
  | 0xFD0 | 0x04 |
  | 0xFD4 | 0 |
  | 0xFD8 | 0 |
  | 0xFDC | 0 |
  | 0xFE0 | VERSION (default 0x60) |
  | 0xFE4 | 0xB8 |
  | 0xFE8 | 0x1B |
  | 0xFEC | 0 |
  | 0xFF0 | 0x0D |
  | 0xFF4 | 0xF0 |
  | 0xFF8 | 0x05 |
  | 0xFFC | 0xB1 |

- R11: `bus_rvalid` is 1 in exactly the cycle after an accepted read request, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | Request present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_wstrb | input | 4 | Byte enables for writes |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| bus_rdata | output | 32 | Read data |
| sec_map_o | output | 32*NUM_WORDS | Flat table, 1 = block non-secure |

## Verification
The bench concentrates on the index path, because that is where a wrong design diverges quietly. It checks four cases:
- A partial-strobe write must not step the index. A design that steps it would corrupt the next word written.
- A write of an over-range index must be dropped. A design that truncates it would alias onto a low word.
- Auto-step must stop one past the end. A design that wraps would overwrite word 0.
- A write that the lock drops must not step the index either. A design that steps it would desynchronise software reads.

It also checks the lock itself: the lock must survive a write of 0 to the control register, and it must freeze the exported table bits. Finally, it checks the order of the identification words and the one-cycle read timing.

// File: rtl/sblut_pkg.sv
package sblut_pkg;

  localparam logic [11:0] OFS_CTRL    = 12'h000;
  localparam logic [11:0] OFS_BMAX    = 12'h010;
  localparam logic [11:0] OFS_BCFG    = 12'h014;
  localparam logic [11:0] OFS_IDX     = 12'h018;
  localparam logic [11:0] OFS_DATA    = 12'h01C;
  localparam logic [11:0] OFS_ID_BASE = 12'hFD0;

  localparam int CTRL_STEP_BIT = 8;
  localparam int CTRL_LOCK_BIT = 31;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_BMAX,
    SEL_BCFG,
    SEL_IDX,
    SEL_DATA,
    SEL_ID
  } reg_sel_e;

  // Map a byte offset onto the register it names.
  function automatic reg_sel_e decode_sel(input logic [11:0] a);
    reg_sel_e s;
    s = SEL_NONE;
    if (a[1:0] == 2'b00) begin
      if (a >= OFS_ID_BASE) s = SEL_ID;
      else begin
        case (a)
          OFS_CTRL: s = SEL_CTRL;
          OFS_BMAX: s = SEL_BMAX;
          OFS_BCFG: s = SEL_BCFG;
          OFS_IDX:  s = SEL_IDX;
          OFS_DATA: s = SEL_DATA;
          default:  s = SEL_NONE;
        endcase
      end
    end
    return s;
  endfunction

  // Slot number of an identification word, counted from the first one.
  function automatic logic [3:0] id_slot(input logic [11:0] a);
    logic [11:0] d;
    d = a - OFS_ID_BASE;
    return d[5:2];
  endfunction

  // Constant identification contents; slot 4 carries the version code.
  function automatic logic [31:0] id_value(input logic [3:0] slot, input logic [7:0] ver);
    logic [7:0] b;
    case (slot)
      4'd0:    b = 8'h04;
      4'd4:    b = ver;
      4'd5:    b = 8'hB8;
      4'd6:    b = 8'h1B;
      4'd8:    b = 8'h0D;
      4'd9:    b = 8'hF0;
      4'd10:   b = 8'h05;
      4'd11:   b = 8'hB1;
      default: b = 8'h00;
    endcase
    return {24'h0, b};
  endfunction

  // Byte-enable merge of new data into an old word.
  function automatic logic [31:0] merge_bytes(input logic [31:0] old_w,
                                              input logic [31:0] new_w,
                                              input logic [3:0]  strb);
    logic [31:0] r;
    for (int i = 0; i < 4; i++)
      r[i*8 +: 8] = strb[i] ? new_w[i*8 +: 8] : old_w[i*8 +: 8];
    return r;
  endfunction

endpackage

// File: rtl/sblut_ctl.sv
module sblut_ctl
  import sblut_pkg::*;
#(
  parameter int NUM_WORDS = 8,
  parameter int IW        = $clog2(NUM_WORDS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_we,
  input  logic          idx_we,
  input  logic          data_step,
  input  logic [31:0]   wdata,
  input  logic [3:0]    wstrb,
  output logic          step_en_q,
  output logic          lock_q,
  output logic [IW-1:0] idx_q,
  output logic          idx_adv
);

  localparam logic [31:0] MAX_IDX = 32'(NUM_WORDS - 1);
  localparam logic [IW-1:0] END_IDX = IW'(NUM_WORDS);

  logic [31:0] idx_new;

  assign idx_new = merge_bytes({{(32-IW){1'b0}}, idx_q}, wdata, wstrb);
  assign idx_adv = data_step && step_en_q && (idx_q != END_IDX);

  // Control: auto-step is read/write, lock only ever goes from 0 to 1.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_en_q <= 1'b0;
      lock_q    <= 1'b0;
    end else if (ctrl_we) begin
      if (wstrb[1]) step_en_q <= wdata[CTRL_STEP_BIT];
      if (wstrb[3] && wdata[CTRL_LOCK_BIT]) lock_q <= 1'b1;
    end
  end

  // Index: explicit writes beyond the last word are dropped.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_we) begin
      if (idx_new <= MAX_IDX) idx_q <= idx_new[IW-1:0];
    end else if (idx_adv) begin
      idx_q <= idx_q + 1'b1;
    end
  end

endmodule

// File: rtl/sblut_store.sv
module sblut_store
  import sblut_pkg::*;
#(
  parameter int NUM_WORDS = 8,
  parameter int IW        = $clog2(NUM_WORDS + 1),
  parameter int MAPW      = 32 * NUM_WORDS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [IW-1:0]   widx,
  input  logic [31:0]     wdata,
  input  logic [3:0]      wstrb,
  output logic [MAPW-1:0] map
);

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic [31:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '0;
      else if (we && (widx == IW'(w))) word_q <= merge_bytes(word_q, wdata, wstrb);
    end
    assign map[w*32 +: 32] = word_q;
  end

endmodule

// File: rtl/sblut_rdpath.sv
module sblut_rdpath
  import sblut_pkg::*;
#(
  parameter int NUM_WORDS = 8,
  parameter int BLK_CFG   = 3,
  parameter logic [7:0] VERSION = 8'h60,
  parameter int IW        = $clog2(NUM_WORDS + 1),
  parameter int MAPW      = 32 * NUM_WORDS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_en,
  input  reg_sel_e        sel,
  input  logic [3:0]      slot,
  input  logic [31:0]     ctrl_val,
  input  logic [IW-1:0]   idx,
  input  logic [MAPW-1:0] map,
  output logic            rvalid,
  output logic [31:0]     rdata
);

  logic [31:0] cur_word;
  logic [31:0] rd_next;

  // Word at the current index; zero when the index is past the end.
  always_comb begin
    cur_word = '0;
    for (int w = 0; w < NUM_WORDS; w++)
      if (idx == IW'(w)) cur_word = map[w*32 +: 32];
  end

  always_comb begin
    case (sel)
      SEL_CTRL: rd_next = ctrl_val;
      SEL_BMAX: rd_next = 32'(NUM_WORDS - 1);
      SEL_BCFG: rd_next = 32'(BLK_CFG);
      SEL_IDX:  rd_next = 32'(idx);
      SEL_DATA: rd_next = cur_word;
      SEL_ID:   rd_next = id_value(slot, VERSION);
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= rd_next;
    end
  end

endmodule

// File: rtl/sec_blk_lut.sv
module sec_blk_lut
  import sblut_pkg::*;
#(
  parameter int NUM_WORDS = 8,
  parameter int BLK_CFG   = 3,
  parameter logic [7:0] VERSION = 8'h60,
  localparam int IW       = $clog2(NUM_WORDS + 1),
  localparam int MAPW     = 32 * NUM_WORDS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_valid,
  input  logic            bus_write,
  input  logic [11:0]     bus_addr,
  input  logic [31:0]     bus_wdata,
  input  logic [3:0]      bus_wstrb,
  output logic            bus_rvalid,
  output logic [31:0]     bus_rdata,
  output logic [MAPW-1:0] sec_map_o
);

  reg_sel_e      sel;
  logic          step_en_q;
  logic          lock_q;
  logic [IW-1:0] cur_idx;
  logic          idx_adv;
  logic [31:0]   ctrl_val;

  // Named events, also observed by the checker.
  logic wr_acc;
  logic rd_acc;
  logic ctrl_wr_ev;
  logic idx_wr_ev;
  logic lut_wr_ev;
  logic data_step_ev;
  logic idx_in_range;
  logic full_word;

  assign sel          = decode_sel(bus_addr);
  assign wr_acc       = bus_valid && bus_write;
  assign rd_acc       = bus_valid && !bus_write;
  assign full_word    = &bus_wstrb;
  assign idx_in_range = cur_idx < IW'(NUM_WORDS);

  assign ctrl_wr_ev   = wr_acc && (sel == SEL_CTRL) && !lock_q;
  assign idx_wr_ev    = wr_acc && (sel == SEL_IDX)  && !lock_q;
  assign lut_wr_ev    = wr_acc && (sel == SEL_DATA) && !lock_q && idx_in_range;
  assign data_step_ev = (sel == SEL_DATA) &&
                        (rd_acc || (wr_acc && full_word && !lock_q));

  assign ctrl_val = {lock_q, 22'h0, step_en_q, 8'h0};

  sblut_ctl #(.NUM_WORDS(NUM_WORDS), .IW(IW)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_we   (ctrl_wr_ev),
    .idx_we    (idx_wr_ev),
    .data_step (data_step_ev),
    .wdata     (bus_wdata),
    .wstrb     (bus_wstrb),
    .step_en_q (step_en_q),
    .lock_q    (lock_q),
    .idx_q     (cur_idx),
    .idx_adv   (idx_adv)
  );

  sblut_store #(.NUM_WORDS(NUM_WORDS), .IW(IW), .MAPW(MAPW)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (lut_wr_ev),
    .widx  (cur_idx),
    .wdata (bus_wdata),
    .wstrb (bus_wstrb),
    .map   (sec_map_o)
  );

  sblut_rdpath #(.NUM_WORDS(NUM_WORDS), .BLK_CFG(BLK_CFG), .VERSION(VERSION),
                 .IW(IW), .MAPW(MAPW)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_acc),
    .sel      (sel),
    .slot     (id_slot(bus_addr)),
    .ctrl_val (ctrl_val),
    .idx      (cur_idx),
    .map      (sec_map_o),
    .rvalid   (bus_rvalid),
    .rdata    (bus_rdata)
  );

endmodule

// File: rtl/sblut_chk.sv
module sblut_chk
  import sblut_pkg::*;
#(
  parameter int NUM_WORDS = 8,
  parameter int IW        = $clog2(NUM_WORDS + 1),
  parameter int MAPW      = 32 * NUM_WORDS
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_valid,
  input logic            bus_write,
  input logic [11:0]     bus_addr,
  input logic [31:0]     bus_wdata,
  input logic [3:0]      bus_wstrb,
  input logic            bus_rvalid,
  input logic            lock_q,
  input logic [IW-1:0]   cur_idx,
  input logic            idx_adv,
  input logic [MAPW-1:0] sec_map_o
);

  // R8
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);

  // R9
  map_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(sec_map_o));

  // R11
  rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> bus_rvalid);

  // R11
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |=> !bus_rvalid);

  // R7
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_idx <= IW'(NUM_WORDS));

  // R6
  idx_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr == OFS_IDX && (&bus_wstrb) &&
     bus_wdata > 32'(NUM_WORDS - 1)) |=> $stable(cur_idx));

  // R5
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_adv |=> cur_idx == $past(cur_idx) + 1'b1);

  // R4
  partial_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr == OFS_DATA && !(&bus_wstrb)) |=> $stable(cur_idx));

endmodule

bind sec_blk_lut sblut_chk #(.NUM_WORDS(NUM_WORDS)) u_sblut_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_wstrb (bus_wstrb),
  .bus_rvalid(bus_rvalid),
  .lock_q    (lock_q),
  .cur_idx   (cur_idx),
  .idx_adv   (idx_adv),
  .sec_map_o (sec_map_o)
);

// File: tb/sec_blk_lut_test.sv
module sec_blk_lut_test;

  localparam int CLK_PERIOD = 10;
  localparam int NW = 8;

  localparam logic [11:0] A_CTRL = 12'h000;
  localparam logic [11:0] A_BMAX = 12'h010;
  localparam logic [11:0] A_BCFG = 12'h014;
  localparam logic [11:0] A_IDX  = 12'h018;
  localparam logic [11:0] A_DATA = 12'h01C;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_valid = 1'b0;
  logic            bus_write = 1'b0;
  logic [11:0]     bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [3:0]      bus_wstrb = '0;
  logic            bus_rvalid;
  logic [31:0]     bus_rdata;
  logic [32*NW-1:0] sec_map_o;

  int checks = 0;
  int failures = 0;
  logic [31:0] exp_w [NW];

  always #(CLK_PERIOD/2) clk = ~clk;

  sec_blk_lut #(.NUM_WORDS(NW), .BLK_CFG(3), .VERSION(8'h60)) uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wstrb(bus_wstrb),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .sec_map_o(sec_map_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic check_map(input string tag);
    logic ok;
    ok = 1'b1;
    for (int w = 0; w < NW; w++)
      if (sec_map_o[w*32 +: 32] !== exp_w[w]) ok = 1'b0;
    checks++;
    if (!ok) begin
      failures++;
      for (int w = 0; w < NW; w++)
        if (sec_map_o[w*32 +: 32] !== exp_w[w])
          $display("FAIL %s word%0d act=%h exp=%h", tag, w, sec_map_o[w*32 +: 32], exp_w[w]);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d; bus_wstrb = s;
    @(posedge clk);
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; bus_wstrb = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
    check("R11 rvalid after read", 32'(bus_rvalid), 32'd1);
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(tag, d, exp);
  endtask

  function automatic logic [31:0] exp_id(input int slot);
    case (slot)
      0: return 32'h04;
      4: return 32'h60;
      5: return 32'hB8;
      6: return 32'h1B;
      8: return 32'h0D;
      9: return 32'hF0;
      10: return 32'h05;
      11: return 32'hB1;
      default: return 32'h0;
    endcase
  endfunction

  task automatic t_reset();
    rd_chk("R1 ctrl after reset", A_CTRL, 32'h0);
    rd_chk("R1 index after reset", A_IDX, 32'h0);
    check_map("R1 table cleared");
  endtask

  task automatic t_fixed();
    rd_chk("R2 block max", A_BMAX, 32'd7);
    rd_chk("R2 block cfg", A_BCFG, 32'd3);
    rd_chk("R2 reserved 04", 12'h004, 32'h0);
    rd_chk("R2 reserved 08", 12'h008, 32'h0);
    rd_chk("R2 reserved 0C", 12'h00C, 32'h0);
    @(negedge clk);
    check("R11 rvalid idle", 32'(bus_rvalid), 32'd0);
  endtask

  task automatic t_lut();
    wr(A_IDX, 32'd2, 4'hF);
    wr(A_DATA, 32'hA5A5_0001, 4'hF);
    exp_w[2] = 32'hA5A5_0001;
    rd_chk("R3 data readback", A_DATA, 32'hA5A5_0001);
    rd_chk("R5 no step when off", A_IDX, 32'd2);
    check_map("R3 map words");
    check("R3 bit 64 non-secure", 32'(sec_map_o[64]), 32'd1);
    check("R3 bit 65 secure", 32'(sec_map_o[65]), 32'd0);
  endtask

  task automatic t_strb();
    wr(A_CTRL, 32'h0000_0100, 4'hF);
    wr(A_IDX, 32'd3, 4'hF);
    wr(A_DATA, 32'hFFFF_FFFF, 4'hF);
    exp_w[3] = 32'hFFFF_FFFF;
    rd_chk("R5 full write steps", A_IDX, 32'd4);
    wr(A_IDX, 32'd3, 4'hF);
    wr(A_DATA, 32'h0000_1200, 4'b0010);
    exp_w[3] = 32'hFFFF_12FF;
    rd_chk("R4 partial write no step", A_IDX, 32'd3);
    check_map("R4 byte merge");
  endtask

  task automatic t_step();
    wr(A_IDX, 32'd4, 4'hF);
    wr(A_DATA, 32'h44, 4'hF);
    wr(A_DATA, 32'h55, 4'hF);
    wr(A_DATA, 32'h66, 4'hF);
    exp_w[4] = 32'h44; exp_w[5] = 32'h55; exp_w[6] = 32'h66;
    rd_chk("R5 index after 3 writes", A_IDX, 32'd7);
    check_map("R5 burst writes");
    wr(A_IDX, 32'd4, 4'hF);
    rd_chk("R5 burst read 0", A_DATA, 32'h44);
    rd_chk("R5 burst read 1", A_DATA, 32'h55);
    rd_chk("R5 burst read 2", A_DATA, 32'h66);
    rd_chk("R5 index after 3 reads", A_IDX, 32'd7);
    wr(A_CTRL, 32'h0, 4'hF);
    wr(A_IDX, 32'd5, 4'hF);
    rd_chk("R5 read with step off", A_DATA, 32'h55);
    rd_chk("R5 index held", A_IDX, 32'd5);
  endtask

  task automatic t_range();
    wr(A_IDX, 32'd9, 4'hF);
    rd_chk("R6 oversize index dropped", A_IDX, 32'd5);
    wr(A_IDX, 32'd8, 4'hF);
    rd_chk("R6 index 8 dropped", A_IDX, 32'd5);
    wr(A_CTRL, 32'h0000_0100, 4'hF);
    wr(A_IDX, 32'd7, 4'hF);
    wr(A_DATA, 32'h77, 4'hF);
    exp_w[7] = 32'h77;
    rd_chk("R7 step to end", A_IDX, 32'd8);
    rd_chk("R7 read past end", A_DATA, 32'h0);
    rd_chk("R7 index saturates", A_IDX, 32'd8);
    wr(A_DATA, 32'hDEAD_BEEF, 4'hF);
    check_map("R7 write past end ignored");
    rd_chk("R7 index still end", A_IDX, 32'd8);
  endtask

  task automatic t_lock();
    wr(A_IDX, 32'd2, 4'hF);
    wr(A_CTRL, 32'h8000_0100, 4'hF);
    rd_chk("R8 lock set", A_CTRL, 32'h8000_0100);
    wr(A_CTRL, 32'h0, 4'hF);
    rd_chk("R8 lock sticky", A_CTRL, 32'h8000_0100);
    wr(A_IDX, 32'd0, 4'hF);
    rd_chk("R9 index write ignored", A_IDX, 32'd2);
    wr(A_DATA, 32'hFFFF_FFFF, 4'hF);
    check_map("R9 data write ignored");
    rd_chk("R9 dropped write no step", A_IDX, 32'd2);
    rd_chk("R9 read while locked", A_DATA, 32'hA5A5_0001);
    rd_chk("R9 read steps while locked", A_IDX, 32'd3);
  endtask

  task automatic t_id();
    for (int s = 0; s < 12; s++) begin
      logic [31:0] d;
      rd(12'(12'hFD0 + 4*s), d);
      check($sformatf("R10 id slot %0d", s), d, exp_id(s));
    end
  endtask

  initial begin
    for (int w = 0; w < NW; w++) exp_w[w] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fixed();
    t_lut();
    t_strb();
    t_step();
    t_range();
    t_lock();
    t_id();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule